// File: doc/BRIEF.md
# Boundary Scan Register with Static Mode Control

This block wraps a device's pin-facing latches in a single serial shift register so that board interconnect can be tested without a protocol controller. A two-bit static mode input chooses among normal operation, serial shifting and a parallel clock. Board test moves a pattern in through `scan_in`, applies it to the output pins with one parallel clock (which also samples the input pins), and moves the sampled values out through `scan_out` while the next pattern moves in.

Each cell has a shift stage. Output cells also have an update stage that drives the pin whenever the mode is not normal. Input cells pass the pin value straight to the core. The cell order is fixed and matches the physical order around the die. The bidirectional host bus contributes only its driving side. One clock runs every stage.

Top module: `bscan_boundary`

## Requirements
- R1: While reset is low, every shift and update stage is cleared. After reset, `scan_out` is 0 and, in any mode other than normal, every output pin drives 0.
- R2: Mode code `01` shifts. Each clock loads `scan_in` into cell 0 and moves every cell k into cell k+1. `scan_out` always shows the last cell.
- R3: Mode code `00` is normal. Every output pin follows its core value without a register in the path.
- R4: Mode code `10` is the parallel clock. Each output cell's update stage loads that cell's shift bit. From the next cycle the pin shows that bit for as long as the mode is not `00`. The update stages keep their contents through normal mode.
- R5: In modes other than `00`, output pins change only in the cycle after a parallel clock.
- R6: Input-cell shift stages load their pin value on every clock in modes `00` and `10`. Output-cell shift stages load their core value in mode `10` and hold their value in mode `00`.
- R7: The core-bound values (`core_xmt`, `core_rxpar`, `core_rx`) equal their pins, bit for bit, in every mode.
- R8: With default widths the chain has 49 cells, numbered from the scan-in end: 0–4 `rcv[0..4]` (out), 5 `optoff` (out), 6–10 `xmt[4..0]` (in), 11–20 `tx[0..9]` (out), 21 `txpar` (out), 22 `rxpar` (in), 23–32 `rx[9..0]` (in), 33–48 `hbus[15..0]` (out).
- R9: Mode code `11` holds every shift and update stage unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for every stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00 normal, 01 shift, 10 parallel, 11 hold |
| scan_in | input | 1 | Serial data into cell 0 |
| scan_out | output | 1 | Serial data from the last cell |
| core_rcv | input | RCV_W | Core values for the receive-data pins |
| pin_rcv | output | RCV_W | Receive-data pins |
| core_optoff | input | 1 | Core value for the optical-off pin |
| pin_optoff | output | 1 | Optical-transmitter-off pin |
| pin_xmt | input | XMT_W | Transmit-data pins |
| core_xmt | output | XMT_W | Transmit-data values delivered to the core |
| core_tx | input | SER_W | Core values for the serial transmit pins |
| pin_tx | output | SER_W | Serial transmit pins |
| core_txpar | input | 1 | Core value for transmit parity |
| pin_txpar | output | 1 | Transmit parity pin |
| pin_rxpar | input | 1 | Receive parity pin |
| core_rxpar | output | 1 | Receive parity delivered to the core |
| pin_rx | input | SER_W | Serial receive pins |
| core_rx | output | SER_W | Serial receive values delivered to the core |
| core_hbus | input | HB_W | Core's driven value for the host bus |
| pin_hbus | output | HB_W | Host bus output drivers |

## Verification
The assertions check on every cycle the one-place shift, the hold in mode `11`, the pin transparency in normal mode, the update of the transmit pins after a parallel clock, the stability of the pins in the test modes, the parity capture and the core-side feed-through. Only the bench's scenarios can show the full cell order and the mix of captured core and pin values that shifts out after a parallel or normal clock. The same holds for walking-one placement at the chain ends and in the middle, and for update contents that survive a pass through normal mode.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

   typedef enum logic [1:0] {
      BS_NORMAL   = 2'b00,
      BS_SHIFT    = 2'b01,
      BS_PARALLEL = 2'b10,
      BS_HOLD     = 2'b11
   } bs_mode_e;

   localparam int MAX_CELLS = 256;

   // Marks which chain positions are output cells; position 0 sits next to scan_in.
   function automatic logic [MAX_CELLS-1:0] out_mask(int rw, int xw, int sw, int hw);
      logic [MAX_CELLS-1:0] m;
      logic [MAX_CELLS-1:0] one;
      int k;
      m   = '0;
      one = {{(MAX_CELLS-1){1'b0}}, 1'b1};
      k   = 0;
      for (int i = 0; i < rw + 1; i++) begin   // receive data + optical off
         m = m | (one << k);
         k = k + 1;
      end
      k = k + xw;                              // transmit-data inputs
      for (int i = 0; i < sw + 1; i++) begin   // serial tx + tx parity
         m = m | (one << k);
         k = k + 1;
      end
      k = k + 1 + sw;                          // rx parity + serial rx inputs
      for (int i = 0; i < hw; i++) begin       // host bus drivers
         m = m | (one << k);
         k = k + 1;
      end
      return m;
   endfunction

endpackage

// File: rtl/bscan_cell.sv
module bscan_cell
   import bscan_pkg::*;
#(
   parameter bit IS_OUT = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  bs_mode_e mode,
   input  logic     si,
   input  logic     cap_d,
   output logic     so,
   output logic     par_o
);

   logic sh_q;
   assign so = sh_q;

   generate
      if (IS_OUT) begin : g_out
         logic upd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh_q  <= 1'b0;
               upd_q <= 1'b0;
            end else begin
               case (mode)
                  BS_SHIFT: sh_q <= si;
                  BS_PARALLEL: begin
                     upd_q <= sh_q;
                     sh_q  <= cap_d;
                  end
                  default: ;
               endcase
            end
         end
         assign par_o = (mode == BS_NORMAL) ? cap_d : upd_q;
      end else begin : g_in
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh_q <= 1'b0;
            end else begin
               case (mode)
                  BS_SHIFT:              sh_q <= si;
                  BS_NORMAL, BS_PARALLEL: sh_q <= cap_d;
                  default: ;
               endcase
            end
         end
         assign par_o = cap_d;
      end
   endgenerate

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
   import bscan_pkg::*;
#(
   parameter int             NCELL    = 8,
   parameter logic [NCELL-1:0] OUT_MASK = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  bs_mode_e         mode,
   input  logic             scan_in,
   input  logic [NCELL-1:0] cap_d,
   output logic [NCELL-1:0] par_o,
   output logic [NCELL-1:0] sh_o
);

   generate
      if (NCELL < 2) begin : g_bad_len
         $error("bscan_chain needs at least two cells");
      end
      for (genvar i = 0; i < NCELL; i++) begin : g_cell
         logic si_w;
         if (i == 0) begin : g_head
            assign si_w = scan_in;
         end else begin : g_link
            assign si_w = sh_o[i-1];
         end
         bscan_cell #(.IS_OUT(OUT_MASK[i])) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .mode  (mode),
            .si    (si_w),
            .cap_d (cap_d[i]),
            .so    (sh_o[i]),
            .par_o (par_o[i])
         );
      end
   endgenerate

endmodule

// File: rtl/bscan_boundary.sv
module bscan_boundary
   import bscan_pkg::*;
#(
   parameter int RCV_W = 5,
   parameter int XMT_W = 5,
   parameter int SER_W = 10,
   parameter int HB_W  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode,
   input  logic             scan_in,
   output logic             scan_out,
   input  logic [RCV_W-1:0] core_rcv,
   output logic [RCV_W-1:0] pin_rcv,
   input  logic             core_optoff,
   output logic             pin_optoff,
   input  logic [XMT_W-1:0] pin_xmt,
   output logic [XMT_W-1:0] core_xmt,
   input  logic [SER_W-1:0] core_tx,
   output logic [SER_W-1:0] pin_tx,
   input  logic             core_txpar,
   output logic             pin_txpar,
   input  logic             pin_rxpar,
   output logic             core_rxpar,
   input  logic [SER_W-1:0] pin_rx,
   output logic [SER_W-1:0] core_rx,
   input  logic [HB_W-1:0]  core_hbus,
   output logic [HB_W-1:0]  pin_hbus
);

   localparam int O_RCV = 0;
   localparam int O_OPT = O_RCV + RCV_W;
   localparam int O_XMT = O_OPT + 1;
   localparam int O_TX  = O_XMT + XMT_W;
   localparam int O_TXP = O_TX + SER_W;
   localparam int O_RXP = O_TXP + 1;
   localparam int O_RX  = O_RXP + 1;
   localparam int O_HB  = O_RX + SER_W;
   localparam int NCELL = O_HB + HB_W;
   localparam logic [MAX_CELLS-1:0] MASK_FULL = out_mask(RCV_W, XMT_W, SER_W, HB_W);

   generate
      if (RCV_W < 1 || XMT_W < 1 || SER_W < 1 || HB_W < 1) begin : g_bad_w
         $error("bscan_boundary: every group width must be at least 1");
      end
      if (NCELL > MAX_CELLS) begin : g_bad_n
         $error("bscan_boundary: chain longer than MAX_CELLS");
      end
   endgenerate

   bs_mode_e         mode_e;
   logic [NCELL-1:0] cap_d;
   logic [NCELL-1:0] par_w;
   logic [NCELL-1:0] chain_q;

   assign mode_e = bs_mode_e'(mode);

   // Chain order from scan_in: rcv[0..], optoff, xmt[hi..0], tx[0..], txpar,
   // rxpar, rx[hi..0], hbus[hi..0].
   generate
      for (genvar i = 0; i < RCV_W; i++) begin : g_rcv
         assign cap_d[O_RCV+i] = core_rcv[i];
         assign pin_rcv[i]     = par_w[O_RCV+i];
      end
      for (genvar j = 0; j < XMT_W; j++) begin : g_xmt
         assign cap_d[O_XMT+j]     = pin_xmt[XMT_W-1-j];
         assign core_xmt[XMT_W-1-j] = par_w[O_XMT+j];
      end
      for (genvar j = 0; j < SER_W; j++) begin : g_ser
         assign cap_d[O_TX+j]      = core_tx[j];
         assign pin_tx[j]          = par_w[O_TX+j];
         assign cap_d[O_RX+j]      = pin_rx[SER_W-1-j];
         assign core_rx[SER_W-1-j] = par_w[O_RX+j];
      end
      for (genvar j = 0; j < HB_W; j++) begin : g_hb
         assign cap_d[O_HB+j]      = core_hbus[HB_W-1-j];
         assign pin_hbus[HB_W-1-j] = par_w[O_HB+j];
      end
   endgenerate

   assign cap_d[O_OPT] = core_optoff;
   assign pin_optoff   = par_w[O_OPT];
   assign cap_d[O_TXP] = core_txpar;
   assign pin_txpar    = par_w[O_TXP];
   assign cap_d[O_RXP] = pin_rxpar;
   assign core_rxpar   = par_w[O_RXP];

   bscan_chain #(
      .NCELL    (NCELL),
      .OUT_MASK (MASK_FULL[NCELL-1:0])
   ) u_chain (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode_e),
      .scan_in (scan_in),
      .cap_d   (cap_d),
      .par_o   (par_w),
      .sh_o    (chain_q)
   );

   assign scan_out = chain_q[NCELL-1];

endmodule

// File: rtl/bscan_boundary_chk.sv
module bscan_boundary_chk
   import bscan_pkg::*;
#(
   parameter int RCV_W = 5,
   parameter int XMT_W = 5,
   parameter int SER_W = 10,
   parameter int HB_W  = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       mode,
   input logic             scan_in,
   input logic [RCV_W+XMT_W+2*SER_W+HB_W+3-1:0] chain_q,
   input logic [SER_W-1:0] core_tx,
   input logic [SER_W-1:0] pin_tx,
   input logic [HB_W-1:0]  core_hbus,
   input logic [HB_W-1:0]  pin_hbus,
   input logic [SER_W-1:0] pin_rx,
   input logic [SER_W-1:0] core_rx,
   input logic             pin_rxpar,
   input logic             pin_optoff
);

   localparam int NCELL = RCV_W + XMT_W + 2*SER_W + HB_W + 3;
   localparam int O_TX  = RCV_W + 1 + XMT_W;
   localparam int O_RXP = O_TX + SER_W + 1;

   // R1: stages read zero whenever reset is held
   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |-> (chain_q == '0));

   // R2: one-place shift toward scan_out
   p_shift_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == BS_SHIFT) |=>
      (chain_q == {$past(chain_q[NCELL-2:0]), $past(scan_in)}));

   // R3: normal mode pins follow core
   p_normal_pins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == BS_NORMAL) |-> (pin_tx == core_tx && pin_hbus == core_hbus));

   // R4: a parallel clock moves shift bits to the transmit pins
   p_update_pins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == BS_PARALLEL) ##1 (mode != BS_NORMAL) |->
      (pin_tx == $past(chain_q[O_TX+SER_W-1:O_TX])));

   // R5: test-mode pins stay still unless a parallel clock came before
   p_pins_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != BS_NORMAL && $past(mode) != BS_NORMAL && $past(mode) != BS_PARALLEL)
      |-> ($stable(pin_tx) && $stable(pin_hbus) && $stable(pin_optoff)));

   // R6: input cells sample their pin in normal and parallel modes
   p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == BS_NORMAL || mode == BS_PARALLEL) |=>
      (chain_q[O_RXP] == $past(pin_rxpar)));

   // R7: core side of input cells tracks the pins
   p_core_feed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      core_rx == pin_rx);

   // R9: hold mode freezes the chain
   p_hold_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == BS_HOLD) |=> $stable(chain_q));

endmodule

bind bscan_boundary bscan_boundary_chk #(
   .RCV_W (RCV_W),
   .XMT_W (XMT_W),
   .SER_W (SER_W),
   .HB_W  (HB_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode       (mode),
   .scan_in    (scan_in),
   .chain_q    (chain_q),
   .core_tx    (core_tx),
   .pin_tx     (pin_tx),
   .core_hbus  (core_hbus),
   .pin_hbus   (pin_hbus),
   .pin_rx     (pin_rx),
   .core_rx    (core_rx),
   .pin_rxpar  (pin_rxpar),
   .pin_optoff (pin_optoff)
);

// File: tb/bscan_boundary_test.sv
module bscan_boundary_test;

   localparam int N = 49;

   logic        clk = 1'b0;
   logic        rst_n = 1'b1;
   logic [1:0]  mode = 2'b00;
   logic        scan_in = 1'b0;
   logic        scan_out;
   logic [4:0]  core_rcv = '0, pin_rcv;
   logic        core_optoff = 1'b0, pin_optoff;
   logic [4:0]  pin_xmt = '0, core_xmt;
   logic [9:0]  core_tx = '0, pin_tx;
   logic        core_txpar = 1'b0, pin_txpar;
   logic        pin_rxpar = 1'b0, core_rxpar;
   logic [9:0]  pin_rx = '0, core_rx;
   logic [15:0] core_hbus = '0, pin_hbus;

   int checks = 0;
   int errors = 0;

   logic [N-1:0] model;   // expected shift contents
   logic [N-1:0] upd_m;   // expected update contents

   always #4 clk = ~clk;

   bscan_boundary uut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .scan_in(scan_in), .scan_out(scan_out),
      .core_rcv(core_rcv), .pin_rcv(pin_rcv), .core_optoff(core_optoff),
      .pin_optoff(pin_optoff), .pin_xmt(pin_xmt), .core_xmt(core_xmt),
      .core_tx(core_tx), .pin_tx(pin_tx), .core_txpar(core_txpar),
      .pin_txpar(pin_txpar), .pin_rxpar(pin_rxpar), .core_rxpar(core_rxpar),
      .pin_rx(pin_rx), .core_rx(core_rx), .core_hbus(core_hbus), .pin_hbus(pin_hbus)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // R8 mapping: expected output pins for a given update content
   task automatic check_pins(input string req, input logic [N-1:0] u);
      logic [15:0] hb;
      for (int j = 0; j < 16; j++) hb[15-j] = u[33+j];
      chk(req, "pin_rcv",    64'(pin_rcv),    64'(u[4:0]));
      chk(req, "pin_optoff", 64'(pin_optoff), 64'(u[5]));
      chk(req, "pin_tx",     64'(pin_tx),     64'(u[20:11]));
      chk(req, "pin_txpar",  64'(pin_txpar),  64'(u[21]));
      chk(req, "pin_hbus",   64'(pin_hbus),   64'(hb));
   endtask

   // R6/R8: contents after a clock that samples; out cells load core only when par
   function automatic logic [N-1:0] captured(input logic [N-1:0] prev, input bit par);
      logic [N-1:0] c;
      c = prev;
      if (par) begin
         c[4:0]   = core_rcv;
         c[5]     = core_optoff;
         c[20:11] = core_tx;
         c[21]    = core_txpar;
         for (int j = 0; j < 16; j++) c[33+j] = core_hbus[15-j];
      end
      for (int j = 0; j < 5; j++)  c[6+j]  = pin_xmt[4-j];
      c[22] = pin_rxpar;
      for (int j = 0; j < 10; j++) c[23+j] = pin_rx[9-j];
      return c;
   endfunction

   task automatic rand_io();
      core_rcv    = 5'($urandom);
      core_optoff = 1'($urandom);
      pin_xmt     = 5'($urandom);
      core_tx     = 10'($urandom);
      core_txpar  = 1'($urandom);
      pin_rxpar   = 1'($urandom);
      pin_rx      = 10'($urandom);
      core_hbus   = 16'($urandom);
   endtask

   // R2: shift pat in (cell k ends with pat[k]) while reading old contents out
   task automatic shift_io(input logic [N-1:0] pat, output logic [N-1:0] got);
      got = '0;
      for (int t = 0; t < N; t++) begin
         mode    = 2'b01;
         scan_in = pat[N-1-t];
         #1;
         got[N-1-t] = scan_out;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [N-1:0] pat;
      logic [N-1:0] got;
      void'($urandom(32'h0b5c_a11e));
      #1 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R1", "scan_out after reset", 64'(scan_out), 64'h0);
      mode = 2'b11;
      rand_io();
      #1;
      check_pins("R1", '0);
      model = '0;
      upd_m = '0;
      @(negedge clk);

      for (int it = 0; it < 14; it++) begin
         case (it)
            0: pat = '1;
            1: pat = {25{2'b01}};
            2: pat = N'(1);
            3: pat = N'(1) << 22;
            4: pat = N'(1) << 48;
            5: pat = N'(1) << 33;
            default: pat = {17'($urandom), $urandom};
         endcase
         shift_io(pat, got);
         chk("R2", "shifted out", 64'(got), 64'(model));
         check_pins("R5", upd_m);
         model = pat;

         // R4/R6 parallel clock with fresh core and pin values
         mode = 2'b10;
         rand_io();
         @(negedge clk);
         model = captured(model, 1'b1);
         upd_m = pat;
         mode  = 2'b11;
         #1;
         check_pins("R4", upd_m);

         if (it % 2 == 0) begin
            // R9: hold mode with changing stimulus keeps everything
            for (int h = 0; h < 3; h++) begin
               scan_in = 1'($urandom);
               rand_io();
               @(negedge clk);
            end
            check_pins("R9", upd_m);
         end else begin
            // R3/R7: normal mode, then update contents return
            mode = 2'b00;
            rand_io();
            #1;
            chk("R3", "pin_tx normal", 64'(pin_tx), 64'(core_tx));
            chk("R3", "pin_hbus normal", 64'(pin_hbus), 64'(core_hbus));
            chk("R7", "core_xmt", 64'(core_xmt), 64'(pin_xmt));
            chk("R7", "core_rx", 64'(core_rx), 64'(pin_rx));
            chk("R7", "core_rxpar", 64'(core_rxpar), 64'(pin_rxpar));
            @(negedge clk);
            model = captured(model, 1'b0);
            mode  = 2'b11;
            #1;
            check_pins("R4", upd_m);
            @(negedge clk);
         end
      end

      shift_io('0, got);
      chk("R8", "final shift out", 64'(got), 64'(model));
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule